// File: doc/BRIEF.md
# Tri-Level SAR ADC Controller

This block is the digital sequencer for a 12-bit fully differential successive-approximation converter whose split capacitor DAC is switched around the common-mode level. Every capacitor of both arrays rests at the common-mode reference. The most significant bit therefore needs no capacitor move: the first comparison is made directly on the sampled input. Each later decision moves one capacitor pair away from common mode, one side up and the mirror side down. This resolves 12 bits with 11 switched capacitors per side. Each capacitor has three control lines per side: positive reference, common mode and negative reference.

A conversion is one sampling cycle followed by twelve comparison cycles. The corrected code appears on `data_o` together with a one-cycle `eoc_o` strobe. A calibration run starts when `cal_i` is high together with `start_i`. It shorts the inputs to common mode and performs sixteen back-to-back conversions. The floor of their mean deviation from mid-scale is stored as a signed offset. That offset is subtracted, with saturation, from every later result.

Top module: `sar_vcm_ctrl`

## Requirements
- R1: With an ideal comparator and zero offset, `data_o` equals the input code for every code from 0 to 4095. The comparator decides 1 when the positive side is higher.
- R2: `sample_o` is high for exactly the one cycle after the edge that accepts `start_i`. `eoc_o` rises 13 rising edges after that accepting edge.
- R3: During the first comparison (bit 11), every capacitor on both sides is connected to common mode.
- R4: Bit k+1 sets the position of capacitor k, which has weight 2^k, for k from 10 down to 0. A 1 puts the positive-side capacitor at the negative reference and the negative-side one at the positive reference. A 0 does the reverse. Exactly one more capacitor leaves common mode per comparison cycle.
- R5: `eoc_o` is high for one cycle only. A `start_i` raised while a conversion runs is ignored and is not queued.
- R6: When `eoc_o` is high, and at every point while idle, all switch lines select common mode on both sides.
- R7: Calibration performs 16 consecutive conversions with `short_o` high, taking 208 cycles, and raises no `eoc_o`. The stored offset is floor(sum(raw-2048)/16).
- R8: After calibration, each result is the raw code minus the offset, saturated to 0 and 4095.
- R9: After reset, `eoc_o`, `data_o`, `sample_o` and `short_o` are 0, all lines select common mode, and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion (taken only when idle) |
| cal_i | input | 1 | With start_i: run an offset calibration instead |
| cmp_i | input | 1 | Comparator decision, 1 = positive side higher |
| sample_o | output | 1 | Track phase of the sample-and-hold |
| short_o | output | 1 | Short both inputs to common mode (calibration) |
| sw_p_refp_o | output | 11 | Positive array: capacitor k to positive reference |
| sw_p_vcm_o | output | 11 | Positive array: capacitor k to common mode |
| sw_p_refn_o | output | 11 | Positive array: capacitor k to negative reference |
| sw_n_refp_o | output | 11 | Negative array: capacitor k to positive reference |
| sw_n_vcm_o | output | 11 | Negative array: capacitor k to common mode |
| sw_n_refn_o | output | 11 | Negative array: capacitor k to negative reference |
| data_o | output | 12 | Corrected conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The testbench counts rising edges from the edge that takes `start_i`. It samples at each falling edge, so the conversion state after edge n is seen as count n. `sample_o` is expected at count 0, all-common-mode switching at count 1, and n-1 switched capacitors at count n up to 12. `eoc_o` and `data_o` are expected at count 13, and `eoc_o` must be low again at count 14. A calibration is expected to hold `short_o` for exactly 208 counts with no strobe. The offset's effect is checked on the first conversion that follows.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter int CAL_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cal_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic             short_o,
  output logic [NBITS-2:0] cap_set_o,
  output logic [NBITS-2:0] cap_pol_o,
  output logic             raw_valid_o,
  output logic [NBITS-1:0] raw_code_o,
  output logic             cal_cnv_o,
  output logic             cal_first_o,
  output logic             cal_last_o
);
  localparam int NCAP = NBITS - 1;
  localparam int KW   = $clog2(NBITS);

  sar_state_e          state_q;
  logic [KW-1:0]       k_q;
  logic [KW-1:0]       k_dn;
  logic [NCAP-1:0]     bits_hi_q;
  logic [NCAP-1:0]     cap_set_q;
  logic [NCAP-1:0]     cap_pol_q;
  logic                cal_run_q;
  logic [CAL_LOG2-1:0] cal_cnt_q;

  // named internal events
  logic decide_w;
  logic last_w;

  assign decide_w = (state_q == ST_CONV);
  assign last_w   = decide_w && (k_q == '0);
  assign k_dn     = k_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      k_q       <= '0;
      bits_hi_q <= '0;
      cap_set_q <= '0;
      cap_pol_q <= '0;
      cal_run_q <= 1'b0;
      cal_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_SAMP;
            cal_run_q <= cal_i;
            cal_cnt_q <= '0;
          end
        end
        ST_SAMP: begin
          state_q   <= ST_CONV;
          k_q       <= KW'(NBITS - 1);
          bits_hi_q <= '0;
          cap_set_q <= '0;
          cap_pol_q <= '0;
        end
        ST_CONV: begin
          if (k_q != '0) begin
            bits_hi_q[k_dn] <= cmp_i;
            cap_set_q[k_dn] <= 1'b1;
            cap_pol_q[k_dn] <= cmp_i;
            k_q             <= k_dn;
          end else begin
            cap_set_q <= '0;
            cap_pol_q <= '0;
            if (cal_run_q && (cal_cnt_q != '1)) begin
              cal_cnt_q <= cal_cnt_q + 1'b1;
              state_q   <= ST_SAMP;
            end else begin
              cal_run_q <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o    = (state_q == ST_SAMP);
  assign short_o     = cal_run_q;
  assign cap_set_o   = cap_set_q;
  assign cap_pol_o   = cap_pol_q;
  assign raw_valid_o = last_w;
  assign raw_code_o  = {bits_hi_q, cmp_i};
  assign cal_cnv_o   = cal_run_q;
  assign cal_first_o = (cal_cnt_q == '0);
  assign cal_last_o  = (cal_cnt_q == '1);

  // R3: the comparison after sampling sees no switched capacitor
  assert_msb_all_vcm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> (cap_set_q == '0));

  // R4: each non-final decision moves exactly one more capacitor
  assert_one_cap_per_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && (k_q != '0)) |=> ($countones(cap_set_q) == $countones($past(cap_set_q)) + 1));

  // R5: a start request during a conversion leads to no new sampling phase
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && !last_w && start_i) |=> !sample_o);
endmodule

// File: rtl/sar_sw_drv.sv
module sar_sw_drv #(
  parameter int NCAP = 11
) (
  input  logic [NCAP-1:0] cap_set_i,
  input  logic [NCAP-1:0] cap_pol_i,
  output logic [NCAP-1:0] p_refp_o,
  output logic [NCAP-1:0] p_vcm_o,
  output logic [NCAP-1:0] p_refn_o,
  output logic [NCAP-1:0] n_refp_o,
  output logic [NCAP-1:0] n_vcm_o,
  output logic [NCAP-1:0] n_refn_o
);
  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    // pol = 1: positive side compared higher, pull it down and the mirror up
    assign p_vcm_o[c]  = ~cap_set_i[c];
    assign n_vcm_o[c]  = ~cap_set_i[c];
    assign p_refn_o[c] = cap_set_i[c] &  cap_pol_i[c];
    assign n_refp_o[c] = cap_set_i[c] &  cap_pol_i[c];
    assign p_refp_o[c] = cap_set_i[c] & ~cap_pol_i[c];
    assign n_refn_o[c] = cap_set_i[c] & ~cap_pol_i[c];
  end
endmodule

// File: rtl/sar_ofs.sv
module sar_ofs #(
  parameter int NBITS    = 12,
  parameter int CAL_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_valid_i,
  input  logic [NBITS-1:0] raw_code_i,
  input  logic             cal_cnv_i,
  input  logic             cal_first_i,
  input  logic             cal_last_i,
  output logic [NBITS-1:0] data_o,
  output logic             eoc_o
);
  localparam int AW = NBITS + CAL_LOG2 + 1;
  localparam int OW = NBITS + 1;
  localparam int DW = NBITS + 2;

  // signed distance of a raw code from mid-scale
  function automatic logic signed [AW-1:0] centered(input logic [NBITS-1:0] raw);
    logic signed [AW-1:0] mid;
    mid = AW'(1) <<< (NBITS - 1);
    return signed'(AW'(raw)) - mid;
  endfunction

  // raw minus offset, clamped to the code range
  function automatic logic [NBITS-1:0] sat_sub(input logic [NBITS-1:0] raw,
                                               input logic signed [OW-1:0] off);
    logic signed [DW-1:0] d;
    logic signed [DW-1:0] top;
    top = signed'(DW'((1 << NBITS) - 1));
    d   = signed'(DW'(raw)) - DW'(off);
    if (d < 0)        return '0;
    else if (d > top) return '1;
    else              return d[NBITS-1:0];
  endfunction

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nx;
  logic signed [OW-1:0] off_q;
  logic                 cal_take_w;
  logic                 user_take_w;

  assign cal_take_w  = raw_valid_i && cal_cnv_i;
  assign user_take_w = raw_valid_i && !cal_cnv_i;
  assign acc_nx      = (cal_first_i ? '0 : acc_q) + centered(raw_code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      off_q  <= '0;
      data_o <= '0;
      eoc_o  <= 1'b0;
    end else begin
      eoc_o <= user_take_w;
      if (user_take_w) data_o <= sat_sub(raw_code_i, off_q);
      if (cal_take_w) begin
        acc_q <= acc_nx;
        if (cal_last_i) off_q <= acc_nx[AW-1:CAL_LOG2];
      end
    end
  end

  // R5: strobe lasts a single cycle
  assert_eoc_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);

  // R7: calibration conversions raise no strobe
  assert_cal_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_take_w |=> !eoc_o);
endmodule

// File: rtl/sar_vcm_ctrl.sv
module sar_vcm_ctrl #(
  parameter int NBITS    = 12,
  parameter int CAL_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cal_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic             short_o,
  output logic [NBITS-2:0] sw_p_refp_o,
  output logic [NBITS-2:0] sw_p_vcm_o,
  output logic [NBITS-2:0] sw_p_refn_o,
  output logic [NBITS-2:0] sw_n_refp_o,
  output logic [NBITS-2:0] sw_n_vcm_o,
  output logic [NBITS-2:0] sw_n_refn_o,
  output logic [NBITS-1:0] data_o,
  output logic             eoc_o
);
  localparam int NCAP = NBITS - 1;

  logic [NCAP-1:0]  cap_set_w;
  logic [NCAP-1:0]  cap_pol_w;
  logic             raw_valid_w;
  logic [NBITS-1:0] raw_code_w;
  logic             cal_cnv_w;
  logic             cal_first_w;
  logic             cal_last_w;

  sar_seq #(.NBITS(NBITS), .CAL_LOG2(CAL_LOG2)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cal_i       (cal_i),
    .cmp_i       (cmp_i),
    .sample_o    (sample_o),
    .short_o     (short_o),
    .cap_set_o   (cap_set_w),
    .cap_pol_o   (cap_pol_w),
    .raw_valid_o (raw_valid_w),
    .raw_code_o  (raw_code_w),
    .cal_cnv_o   (cal_cnv_w),
    .cal_first_o (cal_first_w),
    .cal_last_o  (cal_last_w)
  );

  sar_sw_drv #(.NCAP(NCAP)) u_drv (
    .cap_set_i (cap_set_w),
    .cap_pol_i (cap_pol_w),
    .p_refp_o  (sw_p_refp_o),
    .p_vcm_o   (sw_p_vcm_o),
    .p_refn_o  (sw_p_refn_o),
    .n_refp_o  (sw_n_refp_o),
    .n_vcm_o   (sw_n_vcm_o),
    .n_refn_o  (sw_n_refn_o)
  );

  sar_ofs #(.NBITS(NBITS), .CAL_LOG2(CAL_LOG2)) u_ofs (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_valid_i (raw_valid_w),
    .raw_code_i  (raw_code_w),
    .cal_cnv_i   (cal_cnv_w),
    .cal_first_i (cal_first_w),
    .cal_last_i  (cal_last_w),
    .data_o      (data_o),
    .eoc_o       (eoc_o)
  );

  // R6: when the result is presented, the whole array is back at common mode
  assert_vcm_at_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> ((&sw_p_vcm_o) && (&sw_n_vcm_o)));
endmodule

// File: tb/test_sar_vcm_ctrl.sv
module test_sar_vcm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 12;
  localparam int NC   = NB - 1;
  localparam int MID  = 1 << (NB - 1);
  localparam int MAXC = (1 << NB) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cal = 1'b0;
  logic cmp;
  logic sample_o, short_o, eoc_o;
  logic [NC-1:0] p_refp, p_vcm, p_refn, n_refp, n_vcm, n_refn;
  logic [NB-1:0] data_o;

  int xin = 0;
  int oerr = 0;
  int noise = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_vcm_ctrl i_sar_vcm_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cal_i(cal), .cmp_i(cmp),
    .sample_o(sample_o), .short_o(short_o),
    .sw_p_refp_o(p_refp), .sw_p_vcm_o(p_vcm), .sw_p_refn_o(p_refn),
    .sw_n_refp_o(n_refp), .sw_n_vcm_o(n_vcm), .sw_n_refn_o(n_refn),
    .data_o(data_o), .eoc_o(eoc_o)
  );

  // behavioural comparator and differential capacitor array
  always_comb begin : cmp_model
    int r;
    r = (short_o ? 0 : xin - MID) + oerr + noise;
    for (int c = 0; c < NC; c++) begin
      if (p_refn[c] && n_refp[c] && !p_refp[c] && !n_refn[c]) r = r - (1 << c);
      else if (p_refp[c] && n_refn[c] && !p_refn[c] && !n_refp[c]) r = r + (1 << c);
    end
    cmp = (r >= 0);
  end

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  function automatic int floor16(int s);
    int m;
    m = ((s % 16) + 16) % 16;
    return (s - m) / 16;
  endfunction

  function automatic int pat(int i);
    return (i % 5) - 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic conv(input int x, input bit poke, output int code, output int lat,
                      output bit msb_vcm, output bit steps_ok, output bit samp_ok);
    @(negedge clk);
    xin = x; cal = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    samp_ok = sample_o;
    lat = 0; msb_vcm = 1'b0; steps_ok = 1'b1;
    while (!eoc_o && lat < 40) begin
      @(negedge clk);
      lat++;
      start = (poke && lat == 5);
      if (lat == 1) msb_vcm = (&p_vcm) && (&n_vcm);
      if (lat >= 1 && lat <= 12) begin
        if ($countones(~p_vcm) != lat - 1 || $countones(~n_vcm) != lat - 1) steps_ok = 1'b0;
        if (lat >= 2 && sample_o) samp_ok = 1'b0;
      end
    end
    start = 1'b0;
    code = int'(data_o);
  endtask

  task automatic full_check(input int x, input int exp, input bit poke);
    int code, lat;
    bit mv, st, sp;
    conv(x, poke, code, lat, mv, st, sp);
    check(code == exp, "R1/R8 result", code, exp);
    check(lat == 13, "R2 eoc latency", lat, 13);
    check(sp, "R2 sample phase", int'(sp), 1);
    check(mv, "R3 msb all vcm", int'(mv), 1);
    check(st, "R4 one cap per step", int'(st), 1);
    check((&p_vcm) && (&n_vcm), "R6 vcm at eoc", int'(p_vcm), MAXC >> 1);
    @(negedge clk);
    check(!eoc_o, "R5 eoc single cycle", int'(eoc_o), 0);
    if (poke) begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (sample_o) seen = 1'b1;
      end
      check(!seen, "R5 start not queued", int'(seen), 0);
    end
  endtask

  task automatic run_cal(output int exp_off);
    int lat, idx, s;
    bit eoc_seen;
    s = 0;
    for (int i = 0; i < 16; i++) s += clampc(MID + oerr + pat(i)) - MID;
    exp_off = floor16(s);
    @(negedge clk);
    cal = 1'b1; start = 1'b1;
    @(negedge clk);
    cal = 1'b0; start = 1'b0;
    lat = 0; idx = 0; eoc_seen = 1'b0;
    while (short_o && lat < 400) begin
      if (sample_o) begin
        noise = pat(idx);
        idx++;
      end
      @(negedge clk);
      lat++;
      if (eoc_o) eoc_seen = 1'b1;
    end
    noise = 0;
    check(lat == 208, "R7 calibration length", lat, 208);
    check(idx == 16, "R7 calibration conversions", idx, 16);
    check(!eoc_seen, "R7 no eoc in calibration", int'(eoc_seen), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int off;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(!eoc_o && data_o == '0, "R9 reset outputs", int'(data_o), 0);
    check(!sample_o && !short_o, "R9 reset phases", int'({sample_o, short_o}), 0);
    check((&p_vcm) && (&n_vcm) && p_refp == '0 && p_refn == '0 && n_refp == '0 && n_refn == '0,
          "R9 reset switches", int'(p_vcm), MAXC >> 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check((&p_vcm) && (&n_vcm), "R6 idle vcm", int'(p_vcm), MAXC >> 1);

    // R1 exhaustive sweep, zero offset (also proves R9 offset starts at 0)
    for (int x = 0; x <= MAXC; x++) full_check(x, x, 1'b0);

    // R5 start raised mid-conversion
    full_check(1234, 1234, 1'b1);
    full_check(3001, 3001, 1'b1);

    // R7 calibration with negative comparator offset, then R8 correction
    oerr = -7;
    run_cal(off);
    check(off == -8, "R7 expected offset model", off, -8);
    for (int x = 0; x <= MAXC; x += 97)
      full_check(x, clampc(clampc(x + oerr) - off), 1'b0);
    oerr = 0;
    for (int x = 4085; x <= MAXC; x++)   // R8 saturation at top
      full_check(x, clampc(clampc(x + oerr) - off), 1'b0);

    // R7 calibration with positive offset, R8 saturation at bottom
    oerr = 9;
    run_cal(off);
    oerr = 0;
    for (int x = 0; x <= 20; x++)
      full_check(x, clampc(clampc(x + oerr) - off), 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule